// File: doc/BRIEF.md
# Burst Order Address Sequencer

This block sits on the target side of a parallel memory bus. It generates the byte address of every data phase in a burst. When the address phase is strobed, it captures the DWORD-aligned start address. It also captures the two-bit ordering code carried in the two lowest address bits, the data-width select, the cacheline size and whether the command is a write-and-invalidate. After that, each completed transfer moves the address to the next data phase, following the ordering that was captured.

Two orderings are supported. Linear ordering advances by one data width per transfer. Cacheline-wrap ordering walks to the end of the line, folds back to the start of the same line, and then continues at the same offset in the following line. An order the block cannot honour raises a disconnect flag. In that case the surrounding target logic moves exactly one data phase and then terminates with a disconnect, never with a retry.

Top module: `burst_addr_seq`

## Requirements
- R1: On a clock edge with `addr_phase` high, `cur_addr` becomes `addr_in` with bits 1:0 cleared. `disconnect` takes the value decided for the new transaction, replacing any earlier value.
- R2: Order code `addr_in[1:0]`=00 selects linear ordering. With `wide`=0, each clock edge with `xfer_done` high (and no address phase) adds 4 to `cur_addr`.
- R3: With `wide`=1 latched, the per-transfer step is 8 bytes in both linear and wrap ordering.
- R4: Order code 10 selects wrap ordering within a line of `line_dw`×4 bytes. With `line_dw`=4 and a start at 08h, the sequence is 08h, 0Ch, 00h, 04h.
- R5: In wrap ordering, once a full line has been covered, the burst resumes at the start offset of the next line. The example above continues 18h, 1Ch, 10h, 14h.
- R6: Order codes 01 and 11 set `disconnect`=1. While `disconnect` is high, `xfer_done` leaves `cur_addr` unchanged.
- R7: Wrap ordering sets `disconnect`=1 in three cases: `line_dw` is zero, `line_dw` is not a power of two, or `wide`=1 with `line_dw` below 2.
- R8: With `mwi`=1 in the address phase, any order code other than 00 sets `disconnect`=1. Code 00 with `mwi`=1 behaves as normal linear ordering.
- R9: Changes to `line_dw`, `wide`, `mwi` or `addr_in` after the address phase have no effect on the following addresses of that transaction.
- R10: With neither `addr_phase` nor `xfer_done` high, `cur_addr` and `disconnect` hold.
- R11: After reset, `cur_addr` is 0 and `disconnect` is 0.
- R12: When `addr_phase` and `xfer_done` are high on the same edge, the address phase wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_phase | input | 1 | Address-phase strobe |
| addr_in | input | ADDR_W | Address bus; bits 1:0 carry the order code |
| mwi | input | 1 | Command is write-and-invalidate |
| xfer_done | input | 1 | One data phase completed |
| line_dw | input | LS_W | Cacheline size in DWORDs |
| wide | input | 1 | 64-bit data width select |
| cur_addr | output | ADDR_W | Byte address of the current data phase |
| disconnect | output | 1 | Request single-phase disconnect |

## Verification
The hardest case to reach is the wrap at a line boundary with a 64-bit step. At that point the offset must fold back and must also recognise that the line is complete. The stimulus reaches it with a 32-byte line and a start in the middle of the line, then continues into the next line. The frozen-mode case is also hard to reach. It is driven by changing the line size, the width and the command flag in the middle of a burst, and then checking that the address steps still follow the captured values.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic [1:0] {
      ORD_LINEAR = 2'b00,
      ORD_RSV_LO = 2'b01,
      ORD_WRAP   = 2'b10,
      ORD_RSV_HI = 2'b11
   } burst_order_e;

   typedef struct packed {
      logic wrap;   // wrap ordering active
      logic wide;   // 8-byte step
      logic stop;   // single phase then disconnect
   } burst_mode_t;
endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
   import burst_seq_pkg::*;
#(
   parameter int LS_W    = 8,
   parameter bit WRAP_EN = 1'b1,
   parameter bit WIDE_EN = 1'b1
) (
   input  logic [1:0]      order_code,
   input  logic            mwi,
   input  logic [LS_W-1:0] line_dw,
   input  logic            wide_req,
   output burst_mode_t     mode
);
   logic wide_eff;
   logic pow2;
   logic line_fits;
   logic wrap_ok;
   burst_order_e ord;

   assign ord = burst_order_e'(order_code);

   generate
      if (WIDE_EN) begin : g_wide
         assign wide_eff = wide_req;
      end else begin : g_narrow
         assign wide_eff = 1'b0;
      end
   endgenerate

   assign pow2      = (line_dw != '0) && ((line_dw & (line_dw - 1'b1)) == '0);
   assign line_fits = wide_eff ? (line_dw >= LS_W'(2)) : 1'b1;

   generate
      if (WRAP_EN) begin : g_wrap
         assign wrap_ok = pow2 && line_fits;
      end else begin : g_nowrap
         assign wrap_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      mode.wide = wide_eff;
      mode.wrap = 1'b0;
      mode.stop = 1'b0;
      unique case (ord)
         ORD_LINEAR: mode.stop = 1'b0;
         ORD_WRAP: begin
            if (mwi || !wrap_ok) mode.stop = 1'b1;
            else                 mode.wrap = 1'b1;
         end
         default: mode.stop = 1'b1;
      endcase
   end
endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] cur,
   input  logic [ADDR_W-1:0] line_mask,
   input  logic [ADDR_W-1:0] start_off,
   input  burst_mode_t       mode,
   output logic [ADDR_W-1:0] nxt
);
   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] noff;
   logic [ADDR_W-1:0] lin;

   assign step = mode.wide ? ADDR_W'(8) : ADDR_W'(4);
   assign lin  = cur + step;
   assign base = cur & ~line_mask;
   assign noff = ((cur & line_mask) + step) & line_mask;

   always_comb begin
      if (!mode.wrap)            nxt = lin;
      else if (noff == start_off) nxt = base + line_mask + ADDR_W'(1) + noff;
      else                        nxt = base | noff;
   end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LS_W    = 8,
   parameter bit WRAP_EN = 1'b1,
   parameter bit WIDE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_phase,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              mwi,
   input  logic              xfer_done,
   input  logic [LS_W-1:0]   line_dw,
   input  logic              wide,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              disconnect
);
   localparam int LB_W = LS_W + 2;

   generate
      if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_aw
         $error("ADDR_W out of range");
      end
      if (LS_W < 1 || LB_W >= ADDR_W) begin : g_bad_ls
         $error("LS_W must leave room inside ADDR_W");
      end
   endgenerate

   burst_mode_t       mode_new, mode_q;
   logic [ADDR_W-1:0] cur_q, mask_q, start_q, nxt;
   logic [ADDR_W-1:0] addr_al, mask_new;

   assign addr_al  = {addr_in[ADDR_W-1:2], 2'b00};
   assign mask_new = ADDR_W'({line_dw, 2'b00}) - ADDR_W'(1);

   burst_mode_decode #(.LS_W(LS_W), .WRAP_EN(WRAP_EN), .WIDE_EN(WIDE_EN)) u_dec (
      .order_code (addr_in[1:0]),
      .mwi        (mwi),
      .line_dw    (line_dw),
      .wide_req   (wide),
      .mode       (mode_new)
   );

   burst_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
      .cur       (cur_q),
      .line_mask (mask_q),
      .start_off (start_q),
      .mode      (mode_q),
      .nxt       (nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q   <= '0;
         mask_q  <= '0;
         start_q <= '0;
         mode_q  <= '0;
      end else if (addr_phase) begin
         cur_q   <= addr_al;
         mask_q  <= mask_new;
         start_q <= addr_al & mask_new;
         mode_q  <= mode_new;
      end else if (xfer_done && !mode_q.stop) begin
         cur_q   <= nxt;
      end
   end

   assign cur_addr   = cur_q;
   assign disconnect = mode_q.stop;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_phase,
   input logic [ADDR_W-1:0] addr_in,
   input logic              xfer_done,
   input logic              wide,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              disconnect
);
   logic [1:0] ord_s;
   logic       wide_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ord_s  <= 2'b00;
         wide_s <= 1'b0;
      end else if (addr_phase) begin
         ord_s  <= addr_in[1:0];
         wide_s <= wide;
      end
   end

   assert_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      addr_phase |=> cur_addr == ($past(addr_in) & ~ADDR_W'(3)));

   assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cur_addr[1:0] == 2'b00);

   assert_linear_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !addr_phase && ord_s == 2'b00 && !wide_s && !disconnect)
      |=> cur_addr == $past(cur_addr) + ADDR_W'(4));

   assert_linear_wide_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !addr_phase && ord_s == 2'b00 && wide_s && !disconnect)
      |=> cur_addr == $past(cur_addr) + ADDR_W'(8));

   assert_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_phase && addr_in[0]) |=> disconnect);

   assert_disc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (disconnect && !addr_phase) |=> $stable(cur_addr) && disconnect);

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_phase && !xfer_done) |=> $stable(cur_addr) && $stable(disconnect));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr_phase (addr_phase),
   .addr_in    (addr_in),
   .xfer_done  (xfer_done),
   .wide       (wide),
   .cur_addr   (cur_addr),
   .disconnect (disconnect)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
   localparam int AW = 32;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          addr_phase = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic          mwi = 1'b0;
   logic          xfer_done = 1'b0;
   logic [LW-1:0] line_dw = 8'd4;
   logic          wide = 1'b0;
   logic [AW-1:0] cur_addr;
   logic          disconnect;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   burst_addr_seq u_burst_addr_seq (
      .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .addr_in(addr_in),
      .mwi(mwi), .xfer_done(xfer_done), .line_dw(line_dw), .wide(wide),
      .cur_addr(cur_addr), .disconnect(disconnect)
   );

   task automatic chk(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // address phase; results visible at the following negedge
   task automatic aph(logic [AW-1:0] a, logic m, logic w, logic [LW-1:0] ls);
      @(negedge clk);
      addr_phase = 1'b1; addr_in = a; mwi = m; wide = w; line_dw = ls;
      @(negedge clk);
      addr_phase = 1'b0; mwi = 1'b0;
   endtask

   task automatic step();
      @(negedge clk);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
   endtask

   task automatic t_reset();
      chk("R11 addr", cur_addr, '0);
      chk("R11 disc", AW'(disconnect), '0);
   endtask

   task automatic t_linear32();
      aph(32'h0000_1000, 0, 0, 4);
      chk("R1 start", cur_addr, 32'h1000);
      chk("R1 disc", AW'(disconnect), 0);
      for (int i = 1; i <= 3; i++) begin
         step();
         chk("R2 step", cur_addr, 32'h1000 + AW'(4 * i));
      end
   endtask

   task automatic t_linear64();
      aph(32'h0000_2000, 0, 1, 4);
      step(); chk("R3 lin64", cur_addr, 32'h2008);
      step(); chk("R3 lin64", cur_addr, 32'h2010);
   endtask

   task automatic t_wrap();
      logic [AW-1:0] seq [8] = '{32'h0C, 32'h00, 32'h04, 32'h18,
                                 32'h1C, 32'h10, 32'h14, 32'h28};
      aph(32'h0000_000A, 0, 0, 4);
      chk("R4 start", cur_addr, 32'h08);
      chk("R4 disc", AW'(disconnect), 0);
      for (int i = 0; i < 8; i++) begin
         step();
         chk(i < 3 ? "R4 wrap" : "R5 nextline", cur_addr, seq[i]);
      end
   endtask

   task automatic t_wrap64();
      logic [AW-1:0] seq [5] = '{32'h118, 32'h100, 32'h108, 32'h130, 32'h138};
      aph(32'h0000_0112, 0, 1, 8);
      chk("R3 wrap64 start", cur_addr, 32'h110);
      for (int i = 0; i < 5; i++) begin
         step();
         chk("R3 wrap64", cur_addr, seq[i]);
      end
   endtask

   task automatic t_reserved();
      aph(32'h0000_3001, 0, 0, 4);
      chk("R6 code01 disc", AW'(disconnect), 1);
      chk("R6 code01 addr", cur_addr, 32'h3000);
      step(); chk("R6 hold", cur_addr, 32'h3000);
      aph(32'h0000_3103, 0, 0, 4);
      chk("R6 code11 disc", AW'(disconnect), 1);
      step(); chk("R6 hold11", cur_addr, 32'h3100);
      aph(32'h0000_3200, 0, 0, 4);
      chk("R1 disc cleared", AW'(disconnect), 0);
   endtask

   task automatic t_badline();
      aph(32'h0000_0402, 0, 0, 0);
      chk("R7 zero line", AW'(disconnect), 1);
      aph(32'h0000_0402, 0, 0, 6);
      chk("R7 non-pow2", AW'(disconnect), 1);
      aph(32'h0000_0402, 0, 1, 1);
      chk("R7 wide small", AW'(disconnect), 1);
      aph(32'h0000_0402, 0, 0, 1);
      chk("R7 narrow line1 ok", AW'(disconnect), 0);
   endtask

   task automatic t_mwi();
      aph(32'h0000_5002, 1, 0, 4);
      chk("R8 mwi wrap", AW'(disconnect), 1);
      aph(32'h0000_5003, 1, 0, 4);
      chk("R8 mwi rsv", AW'(disconnect), 1);
      aph(32'h0000_5000, 1, 0, 4);
      chk("R8 mwi linear", AW'(disconnect), 0);
      step(); chk("R8 mwi linear step", cur_addr, 32'h5004);
   endtask

   task automatic t_frozen();
      aph(32'h0000_6000, 0, 0, 4);
      @(negedge clk);
      line_dw = 8'd3; wide = 1'b1; addr_in = 32'hFFFF_FFFF; mwi = 1'b1;
      step(); chk("R9 linear frozen", cur_addr, 32'h6004);
      chk("R9 disc frozen", AW'(disconnect), 0);
      mwi = 1'b0;
      aph(32'h0000_700E, 0, 0, 4);
      line_dw = 8'd16; wide = 1'b1;
      step(); chk("R9 wrap frozen", cur_addr, 32'h7000);
   endtask

   task automatic t_hold();
      aph(32'h0000_8004, 0, 0, 4);
      repeat (4) @(negedge clk);
      chk("R10 idle", cur_addr, 32'h8004);
      chk("R10 idle disc", AW'(disconnect), 0);
   endtask

   task automatic t_prio();
      aph(32'h0000_9000, 0, 0, 4);
      @(negedge clk);
      addr_phase = 1'b1; xfer_done = 1'b1; addr_in = 32'h0000_A000;
      @(negedge clk);
      addr_phase = 1'b0; xfer_done = 1'b0;
      chk("R12 priority", cur_addr, 32'hA000);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_linear32();
      t_linear64();
      t_wrap();
      t_wrap64();
      t_reserved();
      t_badline();
      t_mwi();
      t_frozen();
      t_hold();
      t_prio();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule